// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Host Nonmaskable Request

This block gathers interrupt requests for a processor from seven maskable sources: two external pins, a bus fault, a host request bit, a display line match, a window violation and a single-step request. A rising edge on any source latches a pending bit. Software masks pending bits with an enable register and clears them by writing ones. The block presents one request line and a three-bit vector that names the highest-priority source, which is both pending and enabled.

A host control bit raises a nonmaskable interrupt that the enable register cannot block. A companion host mode bit decides whether the processor should save its state when that interrupt is taken. Context saving can therefore be skipped while the stack is not yet set up. The block does not save anything itself. On each acknowledge it registers a save-state indication for the core to act on.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A low-to-high change on a source input sets its pending bit at the next clock edge. A source held high sets it only once. Pending bit positions are: 0 bus fault, 1 external line A (`ext_irq[0]`), 2 external line B (`ext_irq[1]`), 3 host request, 4 display line, 5 window violation, 6 single-step.
- R2: A clock edge with `clr_we` high clears every pending bit whose `clr_mask` bit is 1 and leaves the others unchanged. A new rising edge on the same source in that cycle wins, and the bit stays set.
- R3: A clock edge with `en_we` high loads `en_wdata` into the enable register, which is visible on `en_o`. The pending register is visible on `pend_o`.
- R4: `irq_req` is high exactly when the nonmaskable interrupt is pending or some pending bit has its enable bit set. Clearing an enable bit never clears the pending bit.
- R5: `irq_vec` is 0 while the nonmaskable interrupt is pending. Otherwise it is 1 plus the lowest pending-and-enabled bit position, which gives the order bus fault, A, B, host, display, window, single-step. It is 0 when there is no request.
- R6: A rising edge on `host_nmi` sets the nonmaskable pending flag (`nmi_pend_o`) at the next edge, whatever the enable register holds.
- R7: A clock edge with `irq_ack` high clears the nonmaskable pending flag if it was set. A new `host_nmi` rising edge in the same cycle sets it again. An acknowledge leaves the maskable pending bits unchanged.
- R8: On every acknowledge, `save_state` is loaded with the inverse of `nmi_nosave` if the nonmaskable interrupt was pending, and with 1 otherwise. It holds that value until the next acknowledge.
- R9: A clock edge with `rst` high clears the pending bits, the enable bits, the nonmaskable flag, `save_state` and the edge history of all inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq | input | 2 | External interrupt pins A (bit 0) and B (bit 1) |
| win_viol | input | 1 | Window violation request |
| host_irq | input | 1 | Host interrupt request bit |
| disp_line | input | 1 | Display line reached |
| bus_fault | input | 1 | Bus fault request |
| sstep | input | 1 | Single-step request |
| host_nmi | input | 1 | Host nonmaskable interrupt bit |
| nmi_nosave | input | 1 | Host mode bit: 1 suppresses state save for the nonmaskable interrupt |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 7 | Enable register write data |
| clr_we | input | 1 | Pending clear strobe |
| clr_mask | input | 7 | Write-one-to-clear mask for pending bits |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| pend_o | output | 7 | Pending register |
| en_o | output | 7 | Enable register |
| nmi_pend_o | output | 1 | Nonmaskable interrupt pending |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 3 | Vector of the winning source |
| save_state | output | 1 | Save-state indication registered at acknowledge |

## Verification
The block has no parameters, so the bench builds its only configuration, with seven maskable sources and one nonmaskable source. A behavioural model runs beside the design every clock. With a single configuration, every priority pairing can be reached directly. This includes simultaneous rises on a high and a low source, a nonmaskable interrupt over an empty enable register, a clear and a rise on the same bit in one cycle, and an acknowledge with and without a pending nonmaskable interrupt under both mode settings.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ext_irq,
  input  logic       win_viol,
  input  logic       host_irq,
  input  logic       disp_line,
  input  logic       bus_fault,
  input  logic       sstep,
  input  logic       host_nmi,
  input  logic       nmi_nosave,
  input  logic       en_we,
  input  logic [6:0] en_wdata,
  input  logic       clr_we,
  input  logic [6:0] clr_mask,
  input  logic       irq_ack,
  output logic [6:0] pend_o,
  output logic [6:0] en_o,
  output logic       nmi_pend_o,
  output logic       irq_req,
  output logic [2:0] irq_vec,
  output logic       save_state
);
  localparam int NSRC = 7;

  logic [NSRC-1:0] src, src_q, rise, pend, en, active, clr;
  logic            nmi_q, nmi_rise, nmi_pend, save_q;
  logic [2:0]      vec;

  assign src      = {sstep, win_viol, disp_line, host_irq, ext_irq[1], ext_irq[0], bus_fault};
  assign rise     = src & ~src_q;
  assign nmi_rise = host_nmi & ~nmi_q;
  assign clr      = clr_we ? clr_mask : '0;
  assign active   = pend & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      nmi_q    <= 1'b0;
      pend     <= '0;
      en       <= '0;
      nmi_pend <= 1'b0;
      save_q   <= 1'b0;
    end else begin
      src_q    <= src;
      nmi_q    <= host_nmi;
      pend     <= (pend & ~clr) | rise;
      nmi_pend <= (nmi_pend & ~irq_ack) | nmi_rise;
      if (en_we)   en     <= en_wdata;
      if (irq_ack) save_q <= nmi_pend ? ~nmi_nosave : 1'b1;
    end
  end

  always_comb begin
    vec = 3'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (active[i]) vec = 3'(i + 1);
    if (nmi_pend) vec = 3'd0;
  end

  assign irq_req    = nmi_pend | (|active);
  assign irq_vec    = vec;
  assign pend_o     = pend;
  assign en_o       = en;
  assign nmi_pend_o = nmi_pend;
  assign save_state = save_q;

  a_r1_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (rise != 0) |=> ((pend & $past(rise)) == $past(rise)));

  a_r2_clear_works: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend & $past(clr_mask & ~rise)) == 0));

  a_r5_vec_names_active: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_vec != 3'd0) |-> (pend[irq_vec - 3'd1] && en[irq_vec - 3'd1]));

  a_r6_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    nmi_rise |=> (irq_req && irq_vec == 3'd0));

  a_r7_ack_clears_nmi: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && nmi_pend && !nmi_rise) |=> !nmi_pend);

  a_r8_save_mode: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && nmi_pend) |=> (save_state == !$past(nmi_nosave)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (pend == 0 && en == 0 && !nmi_pend && !save_state));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [1:0] ext_irq = 0;
  logic win_viol = 0, host_irq = 0, disp_line = 0, bus_fault = 0, sstep = 0;
  logic host_nmi = 0, nmi_nosave = 0, en_we = 0, clr_we = 0, irq_ack = 0;
  logic [6:0] en_wdata = 0, clr_mask = 0;
  logic [6:0] pend_o, en_o;
  logic nmi_pend_o, irq_req, save_state;
  logic [2:0] irq_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [6:0] m_pend = 0, m_en = 0, m_srcq = 0;
  logic m_nmi = 0, m_nmiq = 0, m_save = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (.*);

  task automatic model_update();
    logic [6:0] s;
    s = {sstep, win_viol, disp_line, host_irq, ext_irq[1], ext_irq[0], bus_fault};
    if (rst) begin
      m_pend = 0; m_en = 0; m_srcq = 0; m_nmi = 0; m_nmiq = 0; m_save = 0;
    end else begin
      for (int i = 0; i < 7; i++) begin
        bit r;
        r = s[i] && !m_srcq[i];
        if (clr_we && clr_mask[i]) m_pend[i] = 1'b0;
        if (r) m_pend[i] = 1'b1;
      end
      if (irq_ack) m_save = m_nmi ? !nmi_nosave : 1'b1;
      if (irq_ack) m_nmi = 1'b0;
      if (host_nmi && !m_nmiq) m_nmi = 1'b1;
      if (en_we) m_en = en_wdata;
      m_srcq = s;
      m_nmiq = host_nmi;
    end
  endtask

  task automatic step(input string tag);
    bit exp_req;
    int exp_vec;
    model_update();
    @(posedge clk);
    #1;
    exp_req = m_nmi;
    exp_vec = 0;
    if (!m_nmi)
      for (int i = 6; i >= 0; i--)
        if (m_pend[i] && m_en[i]) begin exp_vec = i + 1; exp_req = 1; end
    checks++;
    if (pend_o !== m_pend || en_o !== m_en || nmi_pend_o !== m_nmi ||
        irq_req !== exp_req || irq_vec !== 3'(exp_vec) || save_state !== m_save) begin
      fails++;
      $display("FAIL %s: got pend=%b en=%b nmi=%b req=%b vec=%0d save=%b, expected pend=%b en=%b nmi=%b req=%b vec=%0d save=%b",
               tag, pend_o, en_o, nmi_pend_o, irq_req, irq_vec, save_state,
               m_pend, m_en, m_nmi, exp_req, exp_vec, m_save);
    end
  endtask

  task automatic quiet();
    en_we = 0; clr_we = 0; irq_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #2;
    step("R9 reset"); step("R9 reset");
    rst = 0;
    step("R9 after reset");

    en_we = 1; en_wdata = 7'h7f; step("R3 enable write"); quiet();

    bus_fault = 1; step("R1 bus fault rise");
    step("R1 bus fault held"); step("R5 vec bus fault");
    clr_we = 1; clr_mask = 7'h01; step("R2 clear while held"); quiet();
    step("R1 held level no reset"); bus_fault = 0; step("R1 release");

    ext_irq = 2'b10; sstep = 1; step("R5 ext B and single-step");
    clr_we = 1; clr_mask = 7'h04; step("R2 clear ext B"); quiet();
    step("R5 single-step remains");
    host_irq = 1; disp_line = 1; win_viol = 1; ext_irq = 2'b11; step("R5 many sources");
    en_we = 1; en_wdata = 7'h00; step("R4 mask all"); quiet();
    step("R4 pending kept");
    en_we = 1; en_wdata = 7'h20; step("R4 only window"); quiet();
    step("R5 window vector");

    host_nmi = 1; nmi_nosave = 1; step("R6 nmi rise");
    en_we = 1; en_wdata = 7'h00; step("R6 nmi ignores enable"); quiet();
    irq_ack = 1; step("R7 ack nmi"); quiet();
    step("R8 nosave held");
    irq_ack = 1; step("R7 ack maskable keeps pending"); quiet();
    step("R8 maskable save");
    host_nmi = 0; step("R6 nmi low");
    host_nmi = 1; nmi_nosave = 0; step("R6 second nmi");
    irq_ack = 1; step("R8 ack with save"); quiet();
    host_nmi = 0; step("R7 idle");
    host_nmi = 1; irq_ack = 1; step("R7 ack and rise same cycle"); quiet();
    irq_ack = 1; nmi_nosave = 1; step("R7 ack again"); quiet();

    clr_we = 1; clr_mask = 7'h7f; step("R2 clear all"); quiet();
    sstep = 0; step("R1 drop single-step");
    sstep = 1; clr_we = 1; clr_mask = 7'h40; step("R2 rise wins over clear"); quiet();
    en_we = 1; en_wdata = 7'h41; bus_fault = 1; step("R5 bus fault beats single-step"); quiet();
    step("R5 priority check");
    clr_we = 1; clr_mask = 7'h01; step("R2 partial clear"); quiet();

    rst = 1; step("R9 reset mid-run");
    rst = 0; step("R9 edges after reset");
    step("R9 settled");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule